// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block is a direct-mapped data cache that sits between a processor and a slower word-wide memory. Each line holds four 32-bit words. A store that hits changes only the cached copy and marks the line as modified. Memory sees that data later, when the line is displaced. A store that misses first brings the whole target block into the cache and then merges the stored word, so a line never holds a mix of new and stale words. A load that misses fetches the whole block, installs it, and then returns the requested word.

The processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until an access completes. An access completes on a rising edge where `cpu_req` is high and `cpu_stall` is low. The memory side moves one word per handshake: a beat ends on a rising edge where `mem_valid` and `mem_ready` are both high. On a read beat, `mem_rdata` must be valid in that same cycle.

The controller has four states:
- `S_CMP` (idle/compare). A hit finishes here. A miss goes to `S_WB` if the victim line is valid and dirty, and to `S_FILL` otherwise.
- `S_WB`. Writes back the victim's four words, then goes to `S_FILL`.
- `S_FILL`. Reads the four words of the new block, installs the tag on the last beat, then goes to `S_DONE`.
- `S_DONE`. Completes the original access and returns to `S_CMP`.

Top module: `cwb_cache`

## Requirements
- R1: The address is split as tag = bits [31:12], line index = bits [11:4], word select = bits [3:2]. Bits [1:0] do not affect which word is read or written.
- R2: A load that hits returns the addressed word with `cpu_stall` low in the same cycle it is presented, and causes no memory beat.
- R3: A store that hits updates only the cached word and sets that line's dirty bit. It causes no memory beat.
- R4: On a miss whose victim is invalid or clean, no write beats occur. The controller goes straight to refill, and the load completes after exactly 5 stalled cycles when memory is always ready.
- R5: On a miss whose victim is valid and dirty, the controller first performs four write beats to the victim's address, carrying the victim's current words. The access then completes after exactly 9 stalled cycles when memory is always ready.
- R6: Write-back and refill each use four beats at addresses {tag, index, w, 2'b00} for w = 0,1,2,3 in ascending order. `mem_addr` and `mem_wdata` stay stable while `mem_valid` is high and `mem_ready` is low.
- R7: After a load miss, the block is installed clean and the requested word is returned from the refilled data.
- R8: A store miss fetches the full block before merging the word. The other three words keep their memory values, and the line ends up dirty.
- R9: `cpu_stall` is high from the cycle a miss is detected through write-back and refill, and low in the `S_DONE` cycle, where the access completes.
- R10: Reset clears every valid bit and dirty bit. The first access after reset misses, and the controller is idle with no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when `cpu_stall` is low |
| cpu_stall | output | 1 | Access not yet complete |
| mem_valid | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_wdata | output | 32 | Write-beat data |
| mem_ready | input | 1 | Memory accepts or answers the beat |
| mem_rdata | input | 32 | Read-beat data, valid with `mem_ready` |

## Verification
The bench runs a sequence of access patterns, and each one separates two behaviours:
- A cold load against an immediate re-load with a different byte offset separates a miss from a hit.
- A store hit followed by a conflicting load shows whether the modified line is written back. A second conflicting load on the now-clean line shows that clean victims are simply dropped.
- A store miss followed by loads of its neighbouring words shows whether allocation fetched the block or left stale words. Evicting that line then shows whether the allocate marked it dirty.
- The final pattern repeats a dirty eviction against a memory that accepts only every other cycle. This separates correct beat ordering and signal holding from behaviour that only works when memory is always ready.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int WORDS  = 4;
    localparam int IDX_W  = 8;
    localparam int LINES  = 1 << IDX_W;
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int OFF_W  = BYTE_W + WSEL_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    typedef enum logic [1:0] {
        S_CMP  = 2'd0,
        S_WB   = 2'd1,
        S_FILL = 2'd2,
        S_DONE = 2'd3
    } cwb_state_e;
endpackage

// File: rtl/cwb_line_store.sv
module cwb_line_store
    import cwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WSEL_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mark_dirty,
    input  logic              install,
    input  logic [TAG_W-1:0]  install_tag,
    output logic              line_valid,
    output logic              line_dirty,
    output logic [TAG_W-1:0]  line_tag,
    output logic [DATA_W-1:0] rd_data
);
    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES][WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (install) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end
            if (mark_dirty) begin
                dirty_q[idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (install) begin
            tag_q[idx] <= install_tag;
        end
        if (wr_en) begin
            data_q[idx][wr_word] <= wr_data;
        end
    end

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];
    assign rd_data    = data_q[idx][rd_word];

    AST_DIRTY_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        mark_dirty |=> dirty_q[$past(idx)]); // R3
    AST_INSTALL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        install |=> (valid_q[$past(idx)] && !dirty_q[$past(idx)])); // R7
endmodule

// File: rtl/cwb_ctrl_fsm.sv
module cwb_ctrl_fsm
    import cwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              hit,
    input  logic              victim_dirty,
    input  logic              mem_ready,
    output logic              cpu_stall,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [WSEL_W-1:0] beat,
    output logic              use_beat,
    output logic              wr_en,
    output logic              wr_from_mem,
    output logic              mark_dirty,
    output logic              install
);
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

    cwb_state_e state_q, state_d;
    logic       last;

    assign last = (beat == LAST_BEAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_CMP;
            beat    <= '0;
        end else begin
            state_q <= state_d;
            if (mem_valid && mem_ready) begin
                beat <= beat + 1'b1;
            end
        end
    end

    always_comb begin
        state_d     = state_q;
        cpu_stall   = 1'b0;
        mem_valid   = 1'b0;
        mem_we      = 1'b0;
        use_beat    = 1'b0;
        wr_en       = 1'b0;
        wr_from_mem = 1'b0;
        mark_dirty  = 1'b0;
        install     = 1'b0;
        unique case (state_q)
            S_CMP: begin
                if (cpu_req) begin
                    if (hit) begin
                        wr_en      = cpu_we;
                        mark_dirty = cpu_we;
                    end else begin
                        cpu_stall = 1'b1;
                        state_d   = victim_dirty ? S_WB : S_FILL;
                    end
                end
            end
            S_WB: begin
                cpu_stall = 1'b1;
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                use_beat  = 1'b1;
                if (mem_ready && last) begin
                    state_d = S_FILL;
                end
            end
            S_FILL: begin
                cpu_stall   = 1'b1;
                mem_valid   = 1'b1;
                use_beat    = 1'b1;
                wr_from_mem = 1'b1;
                wr_en       = mem_ready;
                if (mem_ready && last) begin
                    install = 1'b1;
                    state_d = S_DONE;
                end
            end
            S_DONE: begin
                wr_en      = cpu_req && cpu_we;
                mark_dirty = cpu_req && cpu_we;
                state_d    = S_CMP;
            end
        endcase
    end

    AST_BEAT_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !last) |=> (mem_valid && beat == $past(beat) + 1'b1)); // R6
    AST_BEAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (beat == $past(beat))); // R6
endmodule

// File: rtl/cwb_cache.sv
module cwb_cache
    import cwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [TAG_W-1:0]  cpu_tag;
    logic [IDX_W-1:0]  idx;
    logic [WSEL_W-1:0] cpu_word;
    logic              line_valid, line_dirty, hit;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] rd_data;
    logic [WSEL_W-1:0] beat;
    logic              use_beat, wr_en, wr_from_mem, mark_dirty, install;

    assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign idx      = cpu_addr[OFF_W +: IDX_W];
    assign cpu_word = cpu_addr[BYTE_W +: WSEL_W];
    assign hit      = line_valid && (line_tag == cpu_tag);

    cwb_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .hit          (hit),
        .victim_dirty (line_valid && line_dirty),
        .mem_ready    (mem_ready),
        .cpu_stall    (cpu_stall),
        .mem_valid    (mem_valid),
        .mem_we       (mem_we),
        .beat         (beat),
        .use_beat     (use_beat),
        .wr_en        (wr_en),
        .wr_from_mem  (wr_from_mem),
        .mark_dirty   (mark_dirty),
        .install      (install)
    );

    cwb_line_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx         (idx),
        .rd_word     (use_beat ? beat : cpu_word),
        .wr_en       (wr_en),
        .wr_word     (wr_from_mem ? beat : cpu_word),
        .wr_data     (wr_from_mem ? mem_rdata : cpu_wdata),
        .mark_dirty  (mark_dirty),
        .install     (install),
        .install_tag (cpu_tag),
        .line_valid  (line_valid),
        .line_dirty  (line_dirty),
        .line_tag    (line_tag),
        .rd_data     (rd_data)
    );

    assign cpu_rdata = rd_data;
    assign mem_wdata = rd_data;
    assign mem_addr  = {(mem_we ? line_tag : cpu_tag), idx, beat, {BYTE_W{1'b0}}};

    AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> (line_valid && line_dirty)); // R5
    AST_MEM_MEANS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> cpu_stall); // R9
    AST_DONE_HOLDS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_stall) |-> (line_valid && line_tag == cpu_tag)); // R8
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_addr == $past(mem_addr))); // R6
endmodule

// File: tb/cwb_cache_tb.sv
module cwb_cache_tb;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_valid, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_rdata = '0;

    int checks = 0, errors = 0;
    int wcnt = 0, rcnt = 0, unstable = 0;
    logic [31:0] wlog [16];
    logic [31:0] rlog [16];
    logic [31:0] mm [logic [31:0]];
    bit slow = 0, tog = 0;
    bit held = 0;
    logic [31:0] held_addr, held_data;

    always #(CLK_NS/2) clk = ~clk;

    cwb_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h0F0F_0000;
    endfunction

    function automatic logic [31:0] mrd(input logic [31:0] a);
        if (mm.exists(a)) return mm[a];
        return pat(a);
    endfunction

    // memory model: drive after falling edge, record beats once settled
    always begin
        @(negedge clk);
        tog = ~tog;
        mem_ready = slow ? tog : 1'b1;
        mem_rdata = mrd(mem_addr);
        #1;
        if (rst_n) begin
            if (held && (mem_addr !== held_addr || (mem_we && mem_wdata !== held_data)))
                unstable++;
            held = mem_valid && !mem_ready;
            held_addr = mem_addr;
            held_data = mem_wdata;
            if (mem_valid && mem_ready) begin
                if (mem_we) begin
                    mm[mem_addr] = mem_wdata;
                    if (wcnt < 16) wlog[wcnt] = mem_addr;
                    wcnt++;
                end else begin
                    if (rcnt < 16) rlog[rcnt] = mem_addr;
                    rcnt++;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        wcnt = 0;
        rcnt = 0;
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] q, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        cyc = 0;
        #2;
        while (cpu_stall && cyc < 500) begin
            @(negedge clk);
            #2;
            cyc++;
        end
        q = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    localparam logic [31:0] A = 32'h0000_1000;
    localparam logic [31:0] B = 32'h0010_1000;
    localparam logic [31:0] C = 32'h0000_2020;
    localparam logic [31:0] E = 32'h0003_2020;
    localparam logic [31:0] F = 32'h0005_1000;
    localparam logic [31:0] D1 = 32'hDEAD_0001;
    localparam logic [31:0] D2 = 32'hBEEF_0002;
    localparam logic [31:0] D3 = 32'hCAFE_0003;

    task automatic t_reset_cold();
        logic [31:0] q; int cyc;
        chk("R10 idle stall", 32'(cpu_stall), 32'd0);
        chk("R10 idle mem_valid", 32'(mem_valid), 32'd0);
        clear_log();
        access(0, A + 8, 0, q, cyc);
        chk("R10 R4 R9 cold miss cycles", cyc, 5);
        chk("R7 cold load data", q, pat(A + 8));
        chk("R4 no write beats", wcnt, 0);
        chk("R6 read beat count", rcnt, 4);
        for (int i = 0; i < 4; i++) chk("R6 refill order", rlog[i], A + 32'(4 * i));
    endtask

    task automatic t_read_hit();
        logic [31:0] q; int cyc;
        clear_log();
        access(0, A + 32'hB, 0, q, cyc);
        chk("R2 hit cycles", cyc, 0);
        chk("R1 byte offset ignored", q, pat(A + 8));
        chk("R2 no memory beats", rcnt + wcnt, 0);
    endtask

    task automatic t_write_hit();
        logic [31:0] q; int cyc;
        clear_log();
        access(1, A + 4, D1, q, cyc);
        chk("R3 store hit cycles", cyc, 0);
        chk("R3 no memory beats", rcnt + wcnt, 0);
        access(0, A + 4, 0, q, cyc);
        chk("R3 store visible", q, D1);
    endtask

    task automatic t_dirty_evict();
        logic [31:0] q; int cyc;
        clear_log();
        access(0, B + 12, 0, q, cyc);
        chk("R5 R9 dirty miss cycles", cyc, 9);
        chk("R7 load after evict", q, pat(B + 12));
        chk("R5 write beat count", wcnt, 4);
        for (int i = 0; i < 4; i++) chk("R5 R6 writeback order", wlog[i], A + 32'(4 * i));
        chk("R5 modified word written", mrd(A + 4), D1);
        chk("R6 refill starts at word 0", rlog[0], B);
    endtask

    task automatic t_clean_evict();
        logic [31:0] q; int cyc;
        clear_log();
        access(0, A + 4, 0, q, cyc);
        chk("R4 clean victim cycles", cyc, 5);
        chk("R4 no write beats", wcnt, 0);
        chk("R5 data survived writeback", q, D1);
    endtask

    task automatic t_write_miss();
        logic [31:0] q; int cyc;
        clear_log();
        access(1, C + 4, D2, q, cyc);
        chk("R8 store miss cycles", cyc, 5);
        chk("R8 block fetched", rcnt, 4);
        chk("R8 no write beats", wcnt, 0);
        access(0, C + 4, 0, q, cyc);
        chk("R8 merged word", q, D2);
        chk("R8 merged word hit", cyc, 0);
        access(0, C + 8, 0, q, cyc);
        chk("R8 neighbour from memory", q, pat(C + 8));
        clear_log();
        access(0, E, 0, q, cyc);
        chk("R8 line left dirty", cyc, 9);
        chk("R8 merged word written", mrd(C + 4), D2);
        chk("R8 untouched word written", mrd(C), pat(C));
    endtask

    task automatic t_slow_mem();
        logic [31:0] q; int cyc;
        access(1, A, D3, q, cyc);
        chk("R3 store hit", cyc, 0);
        slow = 1;
        clear_log();
        unstable = 0;
        access(0, F + 4, 0, q, cyc);
        slow = 0;
        chk("R7 slow load data", q, pat(F + 4));
        chk("R5 slow write beats", wcnt, 4);
        chk("R5 slow written word", mrd(A), D3);
        for (int i = 0; i < 4; i++) chk("R6 slow refill order", rlog[i], F + 32'(4 * i));
        chk("R6 held while not ready", unstable, 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        t_reset_cold();
        t_read_hit();
        t_write_hit();
        t_dirty_evict();
        t_clean_evict();
        t_write_miss();
        t_slow_mem();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule